// File: doc/BRIEF.md
# Edge/Level Interrupt Aggregator

This block gathers a set of asynchronous interrupt request lines into one interrupt output for a processor. For each line, software chooses whether it triggers on a transition or on a held level, and which polarity counts as active. It can also mask the line from the output. Every request is captured in a sticky pending register. Software reads that register to see which lines fired, and clears bits by writing ones to them.

Each request line first passes through a two-stage synchronizer. Edge detection then compares the synchronized sample with the one taken a cycle earlier. A line in level mode keeps setting its pending bit for as long as its input stays active. When a request and a clear strike the same bit in the same cycle, the request is kept. The output is a registered OR of the pending bits that are not masked.

The processor reaches four registers through a flat port: a write strobe, an address, write data and combinational read data. The mapping of request sources to bit indices belongs to the integration. The default of twelve lines suits a typical system that has buffer, timer, serial, PHY, overrun/underrun, time-pulse, UART and clock-status sources.

Top module: `irq_edge_level_ctrl`

## Requirements
- R1: After reset, the trigger-mode register reads all zeros (level mode), the polarity register reads all ones (active-high), the mask register reads all ones (all lines disabled), the pending register reads zero, and `irq_o` is 0.
- R2: Address 0 is trigger mode (1 = edge), address 1 is polarity, address 2 is mask (1 = disabled), and address 3 is pending. A write to address 0, 1 or 2 stores `reg_wdata`, and reading that address returns the stored value.
- R3: In edge mode, a pending bit sets on a rising input transition when its polarity bit is 1, and on a falling transition when its polarity bit is 0. A steady input sets nothing.
- R4: In level mode, a pending bit sets while the input is high (polarity 1) or low (polarity 0). Clearing it while the input is still active leaves it set. Once the input is inactive, clearing it leaves it at 0.
- R5: A write to address 3 clears each pending bit whose `reg_wdata` bit is 1 and leaves every other bit unchanged. Such a write never sets a bit.
- R6: If a set event and a clear write hit the same pending bit at the same clock edge, the bit ends up set.
- R7: If an input changes before clock edge k, the corresponding pending bit changes at edge k+2 and not earlier, and `irq_o` responds at edge k+3.
- R8: `irq_o` is the OR of the pending bits whose mask bit is 0, registered by one cycle. A masked line still records its requests in the pending register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_LINES | Asynchronous interrupt request lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | N_LINES | Register write data |
| reg_rdata | output | N_LINES | Read data for the addressed register |
| irq_o | output | 1 | Combined interrupt output |

## Verification
The main function is tried with a table of input-pair patterns, each run under a different combination of trigger mode, polarity and mask. Rising and falling transitions in edge mode show whether the polarity bit selects the correct direction. Active-high and active-low held levels show whether level mode follows the input or its inverse. A mixed vector with edge lines, level lines and partial masks shows that each line is decoded on its own and that the mask gates only the output. Directed tests cover the synchronizer latency, partial write-one clearing, a held level surviving a clear, and a request that coincides with a clear.

// File: rtl/irq_edge_level_ctrl.sv
module irq_edge_level_ctrl #(
  parameter int N_LINES = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [N_LINES-1:0] reg_wdata,
  output logic [N_LINES-1:0] reg_rdata,
  output logic               irq_o
);
  localparam logic [1:0] A_MODE = 2'd0;
  localparam logic [1:0] A_POL  = 2'd1;
  localparam logic [1:0] A_MASK = 2'd2;
  localparam logic [1:0] A_PEND = 2'd3;
  localparam logic [N_LINES-1:0] ONES = '1;

  logic [N_LINES-1:0] sync1_q, sync2_q, prev_q;
  logic [N_LINES-1:0] edge_q, pol_q, mask_q, pend_q;
  logic [N_LINES-1:0] rise, fall, edge_hit, level_hit, set_ev, clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= irq_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign rise      = sync2_q & ~prev_q;
  assign fall      = ~sync2_q & prev_q;
  assign edge_hit  = edge_q & ((pol_q & rise) | (~pol_q & fall));
  assign level_hit = ~edge_q & ~(sync2_q ^ pol_q);
  assign set_ev    = edge_hit | level_hit;
  assign clr       = (reg_wr && reg_addr == A_PEND) ? reg_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_q <= '0;
      pol_q  <= ONES;
      mask_q <= ONES;
      pend_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_MODE) edge_q <= reg_wdata;
      if (reg_wr && reg_addr == A_POL)  pol_q  <= reg_wdata;
      if (reg_wr && reg_addr == A_MASK) mask_q <= reg_wdata;
      pend_q <= (pend_q & ~clr) | set_ev;
      irq_o  <= |(pend_q & ~mask_q);
    end
  end

  always_comb begin
    case (reg_addr)
      A_MODE:  reg_rdata = edge_q;
      A_POL:   reg_rdata = pol_q;
      A_MASK:  reg_rdata = mask_q;
      default: reg_rdata = pend_q;
    endcase
  end
endmodule

// File: rtl/irq_edge_level_ctrl_chk.sv
module irq_edge_level_ctrl_chk #(
  parameter int N_LINES = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [1:0]         reg_addr,
  input logic [N_LINES-1:0] pend_q,
  input logic [N_LINES-1:0] mask_q,
  input logic [N_LINES-1:0] edge_q,
  input logic               irq_o
);
  AST_NO_DROP_WITHOUT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 2'd3) |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R5
  AST_IRQ_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~mask_q) == '0) |=> !irq_o); // R8
  AST_IRQ_FROM_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~mask_q) != '0) |=> irq_o); // R8
  AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 2'd0) |=> $stable(edge_q)); // R2
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 2'd2) |=> $stable(mask_q)); // R2
endmodule

bind irq_edge_level_ctrl irq_edge_level_ctrl_chk #(.N_LINES(N_LINES)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .pend_q(pend_q), .mask_q(mask_q), .edge_q(edge_q), .irq_o(irq_o)
);

// File: tb/irq_edge_level_ctrl_tb_top.sv
module irq_edge_level_ctrl_tb_top;
  localparam int N = 12;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic irq_o;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_edge_level_ctrl #(.N_LINES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  // {mode, polarity, mask, input_a, input_b, expected_pending, expected_irq}
  localparam logic [72:0] VEC [0:7] = '{
    {12'h000, 12'hFFF, 12'h000, 12'h000, 12'h0F0, 12'h0F0, 1'b1},
    {12'hFFF, 12'hFFF, 12'h000, 12'h00F, 12'h0F0, 12'h0F0, 1'b1},
    {12'hFFF, 12'h000, 12'h000, 12'h00F, 12'h0F0, 12'h00F, 1'b1},
    {12'h000, 12'h000, 12'h000, 12'hFFF, 12'hF0F, 12'h0F0, 1'b1},
    {12'h0FF, 12'hFFF, 12'hF00, 12'h000, 12'hF0F, 12'hF0F, 1'b1},
    {12'hFFF, 12'hFFF, 12'hFFF, 12'h000, 12'hFFF, 12'hFFF, 1'b0},
    {12'h000, 12'hFFF, 12'h000, 12'h000, 12'h000, 12'h000, 1'b0},
    {12'hFFF, 12'h0F0, 12'hFF0, 12'h5A5, 12'hA5A, 12'h555, 1'b1}
  };

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [N-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, v); check("R1 mode", v, 12'h000);
    rd(2'd1, v); check("R1 polarity", v, 12'hFFF);
    rd(2'd2, v); check("R1 mask", v, 12'hFFF);
    rd(2'd3, v); check("R1 pending", v, 12'h000);
    check("R1 irq", {11'd0, irq_o}, 12'd0);

    // table walk: R2 R3 R4 R8
    for (int i = 0; i < 8; i++) begin
      wr(2'd2, VEC[i][48:37]);
      wr(2'd0, VEC[i][72:61]);
      wr(2'd1, VEC[i][60:49]);
      rd(2'd0, v); check("R2 mode readback", v, VEC[i][72:61]);
      rd(2'd1, v); check("R2 polarity readback", v, VEC[i][60:49]);
      irq_in = VEC[i][36:25];
      idle(5);
      wr(2'd3, 12'hFFF);
      irq_in = VEC[i][24:13];
      idle(6);
      rd(2'd3, v); check("R3/R4 pending pattern", v, VEC[i][12:1]);
      check("R8 irq pattern", {11'd0, irq_o}, {11'd0, VEC[i][0]});
    end

    // R7 latency
    irq_in = '0;
    wr(2'd0, 12'hFFF); wr(2'd1, 12'hFFF); wr(2'd2, 12'h000);
    idle(5);
    wr(2'd3, 12'hFFF);
    idle(2);
    irq_in[2] = 1'b1;
    @(negedge clk); rd(2'd3, v); check("R7 pending after k", v, 12'h000);
    @(negedge clk); rd(2'd3, v); check("R7 pending after k+1", v, 12'h000);
    @(negedge clk); rd(2'd3, v); check("R7 pending after k+2", v, 12'h004);
    check("R7 irq after k+2", {11'd0, irq_o}, 12'd0);
    @(negedge clk); check("R7 irq after k+3", {11'd0, irq_o}, 12'd1);

    // R5 partial clear
    irq_in = '0;
    idle(5);
    wr(2'd3, 12'hFFF);
    irq_in = 12'h003;
    idle(5);
    rd(2'd3, v); check("R5 setup", v, 12'h003);
    wr(2'd3, 12'h001);
    rd(2'd3, v); check("R5 clear only ones", v, 12'h002);
    wr(2'd3, 12'h000);
    rd(2'd3, v); check("R5 zero write no effect", v, 12'h002);

    // R8 mask gates output only
    wr(2'd2, 12'hFFF);
    idle(2);
    check("R8 masked irq", {11'd0, irq_o}, 12'd0);
    rd(2'd3, v); check("R8 masked pending kept", v, 12'h002);
    wr(2'd2, 12'hFFD);
    idle(1);
    check("R8 unmasked irq", {11'd0, irq_o}, 12'd1);

    // R4 held level survives a clear
    wr(2'd0, 12'h000);
    irq_in = 12'h000;
    idle(5);
    wr(2'd3, 12'hFFF);
    irq_in = 12'h001;
    idle(5);
    wr(2'd3, 12'hFFF);
    rd(2'd3, v); check("R4 held level stays set", v, 12'h001);
    irq_in = 12'h000;
    idle(5);
    wr(2'd3, 12'hFFF);
    idle(1);
    rd(2'd3, v); check("R4 released level clears", v, 12'h000);

    // R6 set wins over same-edge clear
    wr(2'd0, 12'hFFF);
    idle(5);
    wr(2'd3, 12'hFFF);
    rd(2'd3, v); check("R6 setup", v, 12'h000);
    irq_in[5] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 12'h020;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(2'd3, v); check("R6 set wins", v, 12'h020);
    wr(2'd3, 12'h020);
    rd(2'd3, v); check("R6 later clear", v, 12'h000);

    finish_run();
  end
endmodule